// File: doc/BRIEF.md
# Mixer Status Key/Value Decoder

The decoder watches the three leading control bytes of every audio data block that arrives from the interface. The first byte is split in two. Bits 7-1 form a status key and bit 0 flags an embedded MIDI byte. When that flag is set, the third byte carries the MIDI byte, and it is passed out whatever key is present. The key and the second byte (the value) form a stream of key/value pairs. This stream reports the settings that were changed from the front panel of the mixer.

Part of the stream sets context. A bus-select key names the mix bus that the following values belong to. Runs of repeated per-channel keys (gain, pan, control) then address successive input channels implicitly, starting from channel 0. The remaining keys carry per-bus or device-wide settings. The decoder keeps the current bus and channel index and emits one update event per accepted pair: bus, channel, parameter code and raw value. Timer keys pass through without disturbing the sequence. Converting values to dB and forwarding MIDI are left to other blocks.

Top module: `panel_status_decoder`

## Requirements
- R1: `ctl_b0[0]` is the MIDI flag. For a block with the flag set, `midi_valid` is high for exactly one cycle and `midi_byte` equals that block's `ctl_b2`, whatever the key. A block with the flag clear gives no MIDI pulse.
- R2: Key 0x0C (`ctl_b0` with bit 0 masked) selects the mix bus given by value bits 7-5 and restarts the channel index. A value whose bits 7-5 name a bus of 4 or above is ignored: the bus and the index both stay as they were.
- R3: Keys 0x14, 0x1C and 0x24 emit updates with parameter codes 0 (channel gain), 1 (channel pan) and 2 (channel control). The bus field is the most recently selected bus and the value is passed unchanged.
- R4: The channel index starts at 0 after each bus-select key and whenever a per-channel key differs from the previous per-channel key. It rises by one after each per-channel update.
- R5: A per-channel value whose index is 20 or more produces no update.
- R6: Key 0x2C (bus gain) emits code 3 and key 0x34 (bus destination in value bits 3-0, mute in bit 4) emits code 4. Both carry the current bus, channel 0 and the raw value.
- R7: Device-wide keys 0x3C (main volume), 0x44 (phones volume), 0x4C (phones assign), 0x6C (boost, bits 7-4 for analog inputs 8..5) and 0x74 (reference level, bit set = +4) emit codes 5 to 9 in that order, with bus 0 and channel 0.
- R8: Timer keys 0x04 and 0xFC and every unlisted key emit no update and change neither the bus nor the channel index.
- R9: Each update is a one-cycle pulse on `upd_valid`, one clock after the block strobe. No update or MIDI pulse appears without a strobe.
- R10: After reset the outputs are zero, the bus is 0 and the channel index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | One-cycle strobe per received data block |
| ctl_b0 | input | 8 | Key (bits 7-1) and MIDI flag (bit 0) |
| ctl_b1 | input | 8 | Status value |
| ctl_b2 | input | 8 | MIDI data byte when flagged |
| upd_valid | output | 1 | Update event strobe |
| upd_bus | output | 2 | Mix bus of the update |
| upd_chan | output | 5 | Channel index of the update |
| upd_param | output | 4 | Parameter code (0-9) |
| upd_value | output | 8 | Raw value |
| midi_valid | output | 1 | MIDI byte strobe |
| midi_byte | output | 8 | Extracted MIDI byte |

## Verification
Both result paths pass through a single register stage, so the update and the MIDI byte for a block appear in the cycle that follows the edge which samples its strobe. The bench drives each block on a falling edge and holds the strobe for one cycle. It reads the outputs on the next falling edge, which is exactly one register stage later. Every block sent is checked there, including the blocks that must produce nothing, so a late, early or stretched pulse is caught as a mismatch. Tracker state such as the bus and index is observed only through the fields of later updates.

// File: rtl/panel_status_pkg.sv
`timescale 1ns/1ps
package panel_status_pkg;
  localparam logic [7:0] KEY_SYNC      = 8'h0C;
  localparam logic [7:0] KEY_CH_GAIN   = 8'h14;
  localparam logic [7:0] KEY_CH_PAN    = 8'h1C;
  localparam logic [7:0] KEY_CH_CTRL   = 8'h24;
  localparam logic [7:0] KEY_BUS_GAIN  = 8'h2C;
  localparam logic [7:0] KEY_BUS_DEST  = 8'h34;
  localparam logic [7:0] KEY_MAIN_VOL  = 8'h3C;
  localparam logic [7:0] KEY_PH_VOL    = 8'h44;
  localparam logic [7:0] KEY_PH_ASSIGN = 8'h4C;
  localparam logic [7:0] KEY_BOOST     = 8'h6C;
  localparam logic [7:0] KEY_REF_LVL   = 8'h74;
  localparam logic [7:0] KEY_TICK_LO   = 8'h04;
  localparam logic [7:0] KEY_TICK_HI   = 8'hFC;

  typedef enum logic [3:0] {
    PAR_CH_GAIN   = 4'd0,
    PAR_CH_PAN    = 4'd1,
    PAR_CH_CTRL   = 4'd2,
    PAR_BUS_GAIN  = 4'd3,
    PAR_BUS_DEST  = 4'd4,
    PAR_MAIN_VOL  = 4'd5,
    PAR_PH_VOL    = 4'd6,
    PAR_PH_ASSIGN = 4'd7,
    PAR_BOOST     = 4'd8,
    PAR_REF_LVL   = 4'd9
  } param_e;

  typedef enum logic [2:0] {
    KIND_IGNORE = 3'd0,
    KIND_SYNC   = 3'd1,
    KIND_CHAN   = 3'd2,
    KIND_BUS    = 3'd3,
    KIND_DEV    = 3'd4
  } kind_e;
endpackage

// File: rtl/status_key_classifier.sv
`timescale 1ns/1ps
module status_key_classifier
  import panel_status_pkg::*;
(
  input  logic [7:0] key_byte,
  output kind_e      kind,
  output param_e     param
);
  logic [7:0] key;
  assign key = {key_byte[7:1], 1'b0};

  always_comb begin
    kind  = KIND_IGNORE;
    param = PAR_CH_GAIN;
    case (key)
      KEY_SYNC:      kind = KIND_SYNC;
      KEY_CH_GAIN:   begin kind = KIND_CHAN; param = PAR_CH_GAIN;   end
      KEY_CH_PAN:    begin kind = KIND_CHAN; param = PAR_CH_PAN;    end
      KEY_CH_CTRL:   begin kind = KIND_CHAN; param = PAR_CH_CTRL;   end
      KEY_BUS_GAIN:  begin kind = KIND_BUS;  param = PAR_BUS_GAIN;  end
      KEY_BUS_DEST:  begin kind = KIND_BUS;  param = PAR_BUS_DEST;  end
      KEY_MAIN_VOL:  begin kind = KIND_DEV;  param = PAR_MAIN_VOL;  end
      KEY_PH_VOL:    begin kind = KIND_DEV;  param = PAR_PH_VOL;    end
      KEY_PH_ASSIGN: begin kind = KIND_DEV;  param = PAR_PH_ASSIGN; end
      KEY_BOOST:     begin kind = KIND_DEV;  param = PAR_BOOST;     end
      KEY_REF_LVL:   begin kind = KIND_DEV;  param = PAR_REF_LVL;   end
      KEY_TICK_LO,
      KEY_TICK_HI:   kind = KIND_IGNORE;
      default:       kind = KIND_IGNORE;
    endcase
  end
endmodule

// File: rtl/status_seq_tracker.sv
`timescale 1ns/1ps
module status_seq_tracker
  import panel_status_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int NUM_CHANS = 20,
  localparam int BUS_W  = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1,
  localparam int CHAN_W = $clog2(NUM_CHANS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev,
  input  kind_e             kind,
  input  param_e            param,
  input  logic [2:0]        bus_sel,
  output logic              emit,
  output logic [BUS_W-1:0]  emit_bus,
  output logic [CHAN_W-1:0] emit_chan
);
  logic [BUS_W-1:0]  bus_q;
  logic [CHAN_W-1:0] chan_q;
  param_e            last_q;
  logic              last_ok_q;

  logic [CHAN_W-1:0] idx_use;
  logic              idx_ok;
  logic              sync_ok;

  assign idx_use = (last_ok_q && last_q == param) ? chan_q : '0;
  assign idx_ok  = idx_use < CHAN_W'(NUM_CHANS);
  assign sync_ok = int'(bus_sel) < NUM_BUSES;

  always_comb begin
    emit      = 1'b0;
    emit_bus  = '0;
    emit_chan = '0;
    if (ev) begin
      case (kind)
        KIND_CHAN: begin
          emit      = idx_ok;
          emit_bus  = bus_q;
          emit_chan = idx_use;
        end
        KIND_BUS: begin
          emit     = 1'b1;
          emit_bus = bus_q;
        end
        KIND_DEV: emit = 1'b1;
        default:  emit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q     <= '0;
      chan_q    <= '0;
      last_q    <= PAR_CH_GAIN;
      last_ok_q <= 1'b0;
    end else if (ev) begin
      if (kind == KIND_SYNC && sync_ok) begin
        bus_q     <= BUS_W'(bus_sel);
        chan_q    <= '0;
        last_ok_q <= 1'b0;
      end else if (kind == KIND_CHAN) begin
        last_q    <= param;
        last_ok_q <= 1'b1;
        chan_q    <= idx_ok ? idx_use + 1'b1 : CHAN_W'(NUM_CHANS);
      end
    end
  end

  // R2: an out-of-range bus selection leaves the bus context alone
  p_bad_sync_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ev && kind == KIND_SYNC && !sync_ok) |=> ($stable(bus_q) && $stable(chan_q)));

  // R8: timer and unknown keys leave the sequence untouched
  p_ignore_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ev && kind == KIND_IGNORE) |=> ($stable(bus_q) && $stable(chan_q)));

  // R4: a valid sync always restarts the index
  p_sync_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (ev && kind == KIND_SYNC && sync_ok) |=> (chan_q == '0));
endmodule

// File: rtl/midi_tap.sv
`timescale 1ns/1ps
module midi_tap (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev,
  input  logic       flag,
  input  logic [7:0] data,
  output logic       midi_valid,
  output logic [7:0] midi_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      midi_valid <= 1'b0;
      midi_byte  <= '0;
    end else begin
      midi_valid <= ev && flag;
      if (ev && flag) midi_byte <= data;
    end
  end
endmodule

// File: rtl/panel_status_decoder.sv
`timescale 1ns/1ps
module panel_status_decoder
  import panel_status_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int NUM_CHANS = 20,
  localparam int BUS_W  = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1,
  localparam int CHAN_W = $clog2(NUM_CHANS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_valid,
  input  logic [7:0]        ctl_b0,
  input  logic [7:0]        ctl_b1,
  input  logic [7:0]        ctl_b2,
  output logic              upd_valid,
  output logic [BUS_W-1:0]  upd_bus,
  output logic [CHAN_W-1:0] upd_chan,
  output logic [3:0]        upd_param,
  output logic [7:0]        upd_value,
  output logic              midi_valid,
  output logic [7:0]        midi_byte
);
  kind_e             kind;
  param_e            param;
  logic              emit;
  logic [BUS_W-1:0]  emit_bus;
  logic [CHAN_W-1:0] emit_chan;

  status_key_classifier u_cls (
    .key_byte (ctl_b0),
    .kind     (kind),
    .param    (param)
  );

  status_seq_tracker #(
    .NUM_BUSES (NUM_BUSES),
    .NUM_CHANS (NUM_CHANS)
  ) u_trk (
    .clk       (clk),
    .rst       (rst),
    .ev        (blk_valid),
    .kind      (kind),
    .param     (param),
    .bus_sel   (ctl_b1[7:5]),
    .emit      (emit),
    .emit_bus  (emit_bus),
    .emit_chan (emit_chan)
  );

  midi_tap u_midi (
    .clk        (clk),
    .rst        (rst),
    .ev         (blk_valid),
    .flag       (ctl_b0[0]),
    .data       (ctl_b2),
    .midi_valid (midi_valid),
    .midi_byte  (midi_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_bus   <= '0;
      upd_chan  <= '0;
      upd_param <= '0;
      upd_value <= '0;
    end else begin
      upd_valid <= emit;
      if (emit) begin
        upd_bus   <= emit_bus;
        upd_chan  <= emit_chan;
        upd_param <= 4'(param);
        upd_value <= ctl_b1;
      end
    end
  end

  // R9: an update only follows a block strobe
  p_upd_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(blk_valid));

  // R1: the MIDI byte comes from a flagged block's third byte
  p_midi_source_r1: assert property (@(posedge clk) disable iff (rst)
    midi_valid |-> ($past(blk_valid) && $past(ctl_b0[0]) && midi_byte == $past(ctl_b2)));

  // R5: channel updates never carry an index past the last channel
  p_chan_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_param <= 4'd2) |-> (int'(upd_chan) < NUM_CHANS));

  // R7: device-wide updates carry neither bus nor channel
  p_devwide_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_param >= 4'd5) |-> (upd_bus == '0 && upd_chan == '0));

  // R6: per-bus updates carry channel 0
  p_busparam_chan_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_param == 4'd3 || upd_param == 4'd4)) |-> (upd_chan == '0));
endmodule

// File: tb/panel_status_decoder_tb_top.sv
`timescale 1ns/1ps
module panel_status_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       blk_valid = 1'b0;
  logic [7:0] ctl_b0 = '0, ctl_b1 = '0, ctl_b2 = '0;
  logic       upd_valid, midi_valid;
  logic [1:0] upd_bus;
  logic [4:0] upd_chan;
  logic [3:0] upd_param;
  logic [7:0] upd_value, midi_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // captured outputs of the last block
  logic       c_uv, c_mv;
  logic [1:0] c_bus;
  logic [4:0] c_ch;
  logic [3:0] c_par;
  logic [7:0] c_val, c_mb;

  always #2.5 clk = ~clk;

  panel_status_decoder dut_i (
    .clk(clk), .rst(rst), .blk_valid(blk_valid),
    .ctl_b0(ctl_b0), .ctl_b1(ctl_b1), .ctl_b2(ctl_b2),
    .upd_valid(upd_valid), .upd_bus(upd_bus), .upd_chan(upd_chan),
    .upd_param(upd_param), .upd_value(upd_value),
    .midi_valid(midi_valid), .midi_byte(midi_byte)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    @(negedge clk);
    ctl_b0 = b0; ctl_b1 = b1; ctl_b2 = b2; blk_valid = 1'b1;
    @(negedge clk);
    blk_valid = 1'b0;
    c_uv = upd_valid; c_bus = upd_bus; c_ch = upd_chan; c_par = upd_param;
    c_val = upd_value; c_mv = midi_valid; c_mb = midi_byte;
  endtask

  task automatic expect_upd(string req, int bus, int ch, int par, int val);
    chk(req, "upd_valid", int'(c_uv), 1);
    chk(req, "upd_bus", int'(c_bus), bus);
    chk(req, "upd_chan", int'(c_ch), ch);
    chk(req, "upd_param", int'(c_par), par);
    chk(req, "upd_value", int'(c_val), val);
  endtask

  task automatic expect_none(string req);
    chk(req, "upd_valid(none)", int'(c_uv), 0);
  endtask

  task automatic t_reset();
    chk("R10", "upd_valid", int'(upd_valid), 0);
    chk("R10", "midi_valid", int'(midi_valid), 0);
    chk("R10", "upd_value", int'(upd_value), 0);
    send(8'h14, 8'h33, 8'h00);          // gain before any sync: bus 0 index 0
    expect_upd("R10", 0, 0, 0, 8'h33);
  endtask

  task automatic t_midi();
    send(8'h05, 8'h00, 8'h90);          // timer key with flag
    chk("R1", "midi_valid", int'(c_mv), 1);
    chk("R1", "midi_byte", int'(c_mb), 8'h90);
    expect_none("R8");
    @(negedge clk);
    chk("R1", "midi pulse width", int'(midi_valid), 0);
    send(8'h04, 8'h00, 8'h77);          // no flag
    chk("R1", "midi_valid clear", int'(c_mv), 0);
  endtask

  task automatic t_gain_run();
    send(8'h0C, 8'h40, 8'h00);          // bus 2
    expect_none("R2");
    for (int i = 0; i < 3; i++) begin
      send(8'h14, 8'(8'h10 + i), 8'h00);
      expect_upd("R3", 2, i, 0, 8'h10 + i);
    end
    send(8'h15, 8'h20, 8'h3C);          // gain plus MIDI
    expect_upd("R3", 2, 3, 0, 8'h20);
    chk("R1", "midi with gain", int'(c_mb), 8'h3C);
  endtask

  task automatic t_timer_mid();
    send(8'h0C, 8'h20, 8'h00);          // bus 1
    send(8'h1C, 8'h40, 8'h00);
    expect_upd("R3", 1, 0, 1, 8'h40);
    send(8'hFC, 8'h12, 8'h00);
    expect_none("R8");
    send(8'h04, 8'h12, 8'h00);
    expect_none("R8");
    send(8'h54, 8'h12, 8'h00);          // unlisted key
    expect_none("R8");
    send(8'h1C, 8'h41, 8'h00);
    expect_upd("R8", 1, 1, 1, 8'h41);
  endtask

  task automatic t_key_change();
    send(8'h0C, 8'h00, 8'h00);          // bus 0
    send(8'h1C, 8'h01, 8'h00);
    send(8'h1C, 8'h02, 8'h00);
    expect_upd("R4", 0, 1, 1, 8'h02);
    send(8'h24, 8'h08, 8'h00);          // key change without sync
    expect_upd("R4", 0, 0, 2, 8'h08);
    send(8'h24, 8'h03, 8'h00);
    expect_upd("R4", 0, 1, 2, 8'h03);
  endtask

  task automatic t_bad_sync();
    send(8'h0C, 8'h60, 8'h00);          // bus 3
    send(8'h14, 8'h05, 8'h00);
    expect_upd("R2", 3, 0, 0, 8'h05);
    send(8'h0C, 8'h80, 8'h00);          // bus 4 -> ignored
    expect_none("R2");
    send(8'h0C, 8'hE0, 8'h00);          // bus 7 -> ignored
    send(8'h14, 8'h06, 8'h00);
    expect_upd("R2", 3, 1, 0, 8'h06);
  endtask

  task automatic t_overflow();
    send(8'h0C, 8'h20, 8'h00);
    for (int i = 0; i < 22; i++) begin
      send(8'h14, 8'(i), 8'h00);
      if (i < 20) expect_upd("R5", 1, i, 0, i);
      else expect_none("R5");
    end
    send(8'h0C, 8'h20, 8'h00);          // sync recovers
    send(8'h14, 8'h7F, 8'h00);
    expect_upd("R4", 1, 0, 0, 8'h7F);
  endtask

  task automatic t_bus_keys();
    send(8'h0C, 8'h60, 8'h00);
    send(8'h2C, 8'h55, 8'h00);
    expect_upd("R6", 3, 0, 3, 8'h55);
    send(8'h35, 8'h13, 8'hA1);
    expect_upd("R6", 3, 0, 4, 8'h13);
    chk("R1", "midi on dest", int'(c_mb), 8'hA1);
  endtask

  task automatic t_device();
    logic [7:0] keys [5] = '{8'h3C, 8'h44, 8'h4C, 8'h6C, 8'h74};
    send(8'h0C, 8'h40, 8'h00);
    for (int i = 0; i < 5; i++) begin
      send(keys[i], 8'(8'h70 + i), 8'h00);
      expect_upd("R7", 0, 0, 5 + i, 8'h70 + i);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    ctl_b0 = 8'h15; ctl_b1 = 8'h44; ctl_b2 = 8'h99; blk_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9", "upd_valid idle", int'(upd_valid), 0);
      chk("R9", "midi_valid idle", int'(midi_valid), 0);
    end
    send(8'h3C, 8'h01, 8'h00);
    @(negedge clk);
    chk("R9", "upd pulse width", int'(upd_valid), 0);
  endtask

  task automatic print_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_midi();
    t_gain_run();
    t_timer_mid();
    t_key_change();
    t_bad_sync();
    t_overflow();
    t_bus_keys();
    t_device();
    t_idle();
    done = 1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end
endmodule